// File: doc/BRIEF.md
# Update-Based Snooping Coherence Controller

This block holds the coherence state, tag and data word for every line of a small direct-mapped cache that sits on a shared snooping bus. Writes are kept coherent by update. When a line is shared, each written word is broadcast so that the other holders can refresh their copies. No copy is ever invalidated. A line is either not present or in one of four valid states: exclusive-clean, shared-clean, shared-modified and modified. Many caches may hold a line shared-clean at the same time. At most one cache holds it shared-modified, and that cache is the owner. The owner supplies cache-to-cache data and must write the line back when the line is replaced.

The processor side uses a level handshake. The requester holds `cpu_req` until `cpu_done` pulses, and the response tells whether the access hit. The block raises `bus_req` on the bus side and holds a command until an external arbiter grants it. The commands are a read (BusRd), an update carrying the written word (BusUpd) and a replacement write-back. During the granted cycle the block samples the wired-OR shared line from the other caches and, on a read, the fill word. Other caches' transactions arrive on the snoop inputs. In the same cycle the block answers with its share assertion and, when it owns the line, with flush data.

Top module: `dragon_coh_ctrl`

## Requirements
- R1: After reset no line is present. `bus_req`, `cpu_done`, `shared_out` and `flush_out` are low, and the first access to any address misses.
- R2: A read miss issues a read (`bus_cmd`=1) for the request address. On grant the line fills with `bus_fill_data`, to shared-clean if `bus_shared_in` is high and to exclusive-clean if it is low. The response carries the fill word with `cpu_hit`=0.
- R3: A write miss first issues a read. If the shared line was high at that grant, an update (`bus_cmd`=2) carrying the written word follows and the line ends shared-modified. Otherwise the line ends modified and no update is issued.
- R4: A write hit in exclusive-clean or modified makes no bus request and leaves the line modified.
- R5: A write hit in shared-clean or shared-modified issues an update with the written word. The local copy keeps its old value until the grant. The line then ends shared-modified if `bus_shared_in` is high and modified if it is low.
- R6: A snooped read of a modified line flushes the line's data and makes it shared-modified. A snooped read of a shared-modified line flushes and keeps that state. A snooped read of an exclusive-clean line makes it shared-clean without a flush. Shared-clean never flushes.
- R7: A snooped update replaces the local word. A shared-modified line that sees it becomes shared-clean, because the other writer is now the owner.
- R8: `shared_out` is high exactly while a snooped read or update addresses a present line. A snooped write-back (`snp_cmd`=3) or a tag mismatch leaves it low.
- R9: A miss whose victim is modified or shared-modified first issues a write-back (`bus_cmd`=3) with the victim's address and word, then the read. A clean victim is dropped with no bus traffic.
- R10: While `bus_req` is high and not granted, the command and address are held. The processor path and the snoop path never write the line store in the same cycle. A new request is not accepted in a cycle with a valid snoop.
- R11: A read hit returns the stored word with `cpu_hit`=1 and makes no bus request. `cpu_done` is a one-cycle pulse. On writes, `cpu_rdata` returns the written word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor request, held until `cpu_done` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | AW | Word address; low IDXW bits select the line |
| cpu_wdata | input | DW | Write word |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_hit | output | 1 | Request hit a present line |
| cpu_rdata | output | DW | Read word, or the written word for writes |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Grant; the transaction happens in this cycle |
| bus_cmd | output | 2 | 0 none, 1 read, 2 update, 3 write-back |
| bus_addr | output | AW | Transaction address |
| bus_data | output | DW | Update word or write-back word |
| bus_shared_in | input | 1 | Wired-OR share line from the other caches |
| bus_fill_data | input | DW | Fill word valid in a granted read cycle |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_cmd | input | 2 | Snooped command, same coding as `bus_cmd` |
| snp_addr | input | AW | Snooped address |
| snp_data | input | DW | Snooped update word |
| shared_out | output | 1 | This cache holds the snooped line |
| flush_out | output | 1 | This cache supplies the snooped line as owner |
| flush_data | output | DW | Word supplied with `flush_out` |

## Verification
A request driven before an edge is accepted at that edge. A hit or a silent write raises `cpu_done` in the following cycle. When bus traffic is needed, `bus_req` is visible in the cycle after acceptance, and the line is written at the grant edge. `cpu_done` follows one cycle after the last grant. Snoop replies are combinational, so the bench samples `shared_out` and `flush_out` a moment after it drives the snoop. The state change is then seen through a later probe. The bench drives on falling edges and reads results just after them. It acts as the arbiter and logs each granted command. It finds each line's state by its behaviour: whether a snooped read flushes, and whether a write hit goes to the bus.

// File: rtl/dragon_pkg.sv
`timescale 1ns/1ps
package dragon_pkg;

    typedef enum logic [2:0] {
        LS_NP  = 3'd0,
        LS_EXC = 3'd1,
        LS_SHC = 3'd2,
        LS_SHM = 3'd3,
        LS_MOD = 3'd4
    } line_st_e;

    typedef enum logic [1:0] {
        BC_NONE = 2'd0,
        BC_RD   = 2'd1,
        BC_UPD  = 2'd2,
        BC_WB   = 2'd3
    } bus_cmd_e;

    typedef enum logic [2:0] {
        CS_IDLE, CS_WB, CS_FILL, CS_UPD, CS_RESP
    } ctl_st_e;

    function automatic logic is_dirty(line_st_e s);
        return (s == LS_MOD) || (s == LS_SHM);
    endfunction

    function automatic line_st_e snoop_next(line_st_e s, bus_cmd_e c);
        line_st_e n = s;
        if (c == BC_RD) begin
            if (s == LS_MOD)      n = LS_SHM;
            else if (s == LS_EXC) n = LS_SHC;
        end else if (c == BC_UPD) begin
            if (s == LS_SHM)      n = LS_SHC;
        end
        return n;
    endfunction

endpackage

// File: rtl/dragon_line_array.sv
`timescale 1ns/1ps
module dragon_line_array
    import dragon_pkg::*;
#(
    parameter int AW   = 8,
    parameter int DW   = 16,
    parameter int IDXW = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [IDXW-1:0]    a_idx,
    output line_st_e           a_st,
    output logic [AW-IDXW-1:0] a_tag,
    output logic [DW-1:0]      a_data,
    input  logic [IDXW-1:0]    b_idx,
    output line_st_e           b_st,
    output logic [AW-IDXW-1:0] b_tag,
    output logic [DW-1:0]      b_data,
    input  logic               cpu_we,
    input  logic [IDXW-1:0]    cpu_idx,
    input  line_st_e           cpu_st,
    input  logic [AW-IDXW-1:0] cpu_tag,
    input  logic [DW-1:0]      cpu_data,
    input  logic               snp_we,
    input  logic [IDXW-1:0]    snp_idx,
    input  line_st_e           snp_st,
    input  logic [DW-1:0]      snp_data
);
    localparam int LINES = 1 << IDXW;
    localparam int TW    = AW - IDXW;

    line_st_e        st_q   [LINES];
    logic [TW-1:0]   tag_q  [LINES];
    logic [DW-1:0]   data_q [LINES];

    assign a_st   = st_q[a_idx];
    assign a_tag  = tag_q[a_idx];
    assign a_data = data_q[a_idx];
    assign b_st   = st_q[b_idx];
    assign b_tag  = tag_q[b_idx];
    assign b_data = data_q[b_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < LINES; i++) begin
                st_q[i]   <= LS_NP;
                tag_q[i]  <= '0;
                data_q[i] <= '0;
            end
        end else if (cpu_we) begin
            st_q[cpu_idx]   <= cpu_st;
            tag_q[cpu_idx]  <= cpu_tag;
            data_q[cpu_idx] <= cpu_data;
        end else if (snp_we) begin
            st_q[snp_idx]   <= snp_st;
            data_q[snp_idx] <= snp_data;
        end
    end

    AST_ONE_WRITER: assert property (@(posedge clk) disable iff (rst)
        !(cpu_we && snp_we)); // R10

endmodule

// File: rtl/dragon_snoop.sv
`timescale 1ns/1ps
module dragon_snoop
    import dragon_pkg::*;
#(
    parameter int AW   = 8,
    parameter int DW   = 16,
    parameter int IDXW = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               snp_valid,
    input  logic [1:0]         snp_cmd,
    input  logic [AW-1:0]      snp_addr,
    input  logic [DW-1:0]      snp_data,
    output logic [IDXW-1:0]    b_idx,
    input  line_st_e           b_st,
    input  logic [AW-IDXW-1:0] b_tag,
    input  logic [DW-1:0]      b_data,
    output logic               shared_out,
    output logic               flush_out,
    output logic [DW-1:0]      flush_data,
    output logic               wr_en,
    output line_st_e           wr_st,
    output logic [DW-1:0]      wr_data
);
    bus_cmd_e cmd;
    logic     hit;

    assign cmd   = bus_cmd_e'(snp_cmd);
    assign b_idx = snp_addr[IDXW-1:0];
    assign hit   = snp_valid && (b_st != LS_NP) && (b_tag == snp_addr[AW-1:IDXW])
                   && (cmd == BC_RD || cmd == BC_UPD);

    assign shared_out = hit;
    assign flush_out  = hit && (cmd == BC_RD) && is_dirty(b_st);
    assign flush_data = b_data;
    assign wr_en      = hit;
    assign wr_st      = snoop_next(b_st, cmd);
    assign wr_data    = (cmd == BC_UPD) ? snp_data : b_data;

    AST_UPD_ON_SHARED: assert property (@(posedge clk) disable iff (rst)
        (hit && cmd == BC_UPD) |-> (b_st == LS_SHC || b_st == LS_SHM)); // R7

endmodule

// File: rtl/dragon_cpu_ctrl.sv
`timescale 1ns/1ps
module dragon_cpu_ctrl
    import dragon_pkg::*;
#(
    parameter int AW   = 8,
    parameter int DW   = 16,
    parameter int IDXW = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cpu_req,
    input  logic               cpu_we,
    input  logic [AW-1:0]      cpu_addr,
    input  logic [DW-1:0]      cpu_wdata,
    output logic               cpu_done,
    output logic               cpu_hit,
    output logic [DW-1:0]      cpu_rdata,
    input  logic               snp_busy,
    output logic               bus_req,
    input  logic               bus_gnt,
    output bus_cmd_e           bus_cmd,
    output logic [AW-1:0]      bus_addr,
    output logic [DW-1:0]      bus_data,
    input  logic               bus_shared_in,
    input  logic [DW-1:0]      bus_fill_data,
    output logic [IDXW-1:0]    a_idx,
    input  line_st_e           a_st,
    input  logic [AW-IDXW-1:0] a_tag,
    input  logic [DW-1:0]      a_data,
    output logic               wr_en,
    output line_st_e           wr_st,
    output logic [AW-IDXW-1:0] wr_tag,
    output logic [DW-1:0]      wr_data
);
    localparam int TW = AW - IDXW;

    ctl_st_e       cs;
    logic [AW-1:0] r_addr;
    logic          r_we;
    logic [DW-1:0] r_wdata;
    logic          r_hit;
    logic [DW-1:0] r_rdata;

    logic [TW-1:0] req_tag;
    logic [TW-1:0] r_tag;
    logic          hit_now;
    logic          accept;
    logic          silent_wr;

    assign a_idx     = (cs == CS_IDLE) ? cpu_addr[IDXW-1:0] : r_addr[IDXW-1:0];
    assign req_tag   = cpu_addr[AW-1:IDXW];
    assign r_tag     = r_addr[AW-1:IDXW];
    assign hit_now   = (a_st != LS_NP) && (a_tag == req_tag);
    assign accept    = (cs == CS_IDLE) && cpu_req && !snp_busy;
    assign silent_wr = hit_now && cpu_we && (a_st == LS_EXC || a_st == LS_MOD);

    assign cpu_done  = (cs == CS_RESP);
    assign cpu_hit   = r_hit;
    assign cpu_rdata = r_rdata;

    always_comb begin
        bus_req  = 1'b0;
        bus_cmd  = BC_NONE;
        bus_addr = r_addr;
        bus_data = '0;
        case (cs)
            CS_WB: begin
                bus_req  = 1'b1;
                bus_cmd  = BC_WB;
                bus_addr = {a_tag, r_addr[IDXW-1:0]};
                bus_data = a_data;
            end
            CS_FILL: begin
                bus_req = 1'b1;
                bus_cmd = BC_RD;
            end
            CS_UPD: begin
                bus_req  = 1'b1;
                bus_cmd  = BC_UPD;
                bus_data = r_wdata;
            end
            default: ;
        endcase
    end

    always_comb begin
        wr_en   = 1'b0;
        wr_st   = LS_NP;
        wr_tag  = r_tag;
        wr_data = r_wdata;
        case (cs)
            CS_IDLE: if (accept && silent_wr) begin
                wr_en   = 1'b1;
                wr_st   = LS_MOD;
                wr_tag  = req_tag;
                wr_data = cpu_wdata;
            end
            CS_WB: if (bus_gnt) begin
                wr_en   = 1'b1;
                wr_st   = LS_NP;
                wr_tag  = a_tag;
                wr_data = a_data;
            end
            CS_FILL: if (bus_gnt) begin
                wr_en = 1'b1;
                if (!r_we) begin
                    wr_st   = bus_shared_in ? LS_SHC : LS_EXC;
                    wr_data = bus_fill_data;
                end else if (bus_shared_in) begin
                    wr_st   = LS_SHC;
                    wr_data = bus_fill_data;
                end else begin
                    wr_st   = LS_MOD;
                end
            end
            CS_UPD: if (bus_gnt) begin
                wr_en = 1'b1;
                wr_st = bus_shared_in ? LS_SHM : LS_MOD;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cs      <= CS_IDLE;
            r_addr  <= '0;
            r_we    <= 1'b0;
            r_wdata <= '0;
            r_hit   <= 1'b0;
            r_rdata <= '0;
        end else begin
            case (cs)
                CS_IDLE: if (accept) begin
                    r_addr  <= cpu_addr;
                    r_we    <= cpu_we;
                    r_wdata <= cpu_wdata;
                    r_hit   <= hit_now;
                    r_rdata <= cpu_we ? cpu_wdata : a_data;
                    if (hit_now)
                        cs <= (!cpu_we || silent_wr) ? CS_RESP : CS_UPD;
                    else
                        cs <= is_dirty(a_st) ? CS_WB : CS_FILL;
                end
                CS_WB: if (bus_gnt) cs <= CS_FILL;
                CS_FILL: if (bus_gnt) begin
                    if (!r_we) begin
                        r_rdata <= bus_fill_data;
                        cs      <= CS_RESP;
                    end else begin
                        cs <= bus_shared_in ? CS_UPD : CS_RESP;
                    end
                end
                CS_UPD: if (bus_gnt) cs <= CS_RESP;
                default: cs <= CS_IDLE;
            endcase
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!bus_req && !cpu_done)); // R1
    AST_RD_ON_MISS: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_cmd == BC_RD) |-> !r_hit); // R2
    AST_CMD_HELD: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_gnt) |=> (bus_req && $stable(bus_cmd) && $stable(bus_addr))); // R10
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        cpu_done |=> !cpu_done); // R11

endmodule

// File: rtl/dragon_coh_ctrl.sv
`timescale 1ns/1ps
module dragon_coh_ctrl
    import dragon_pkg::*;
#(
    parameter int AW   = 8,
    parameter int DW   = 16,
    parameter int IDXW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cpu_req,
    input  logic          cpu_we,
    input  logic [AW-1:0] cpu_addr,
    input  logic [DW-1:0] cpu_wdata,
    output logic          cpu_done,
    output logic          cpu_hit,
    output logic [DW-1:0] cpu_rdata,
    output logic          bus_req,
    input  logic          bus_gnt,
    output logic [1:0]    bus_cmd,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_data,
    input  logic          bus_shared_in,
    input  logic [DW-1:0] bus_fill_data,
    input  logic          snp_valid,
    input  logic [1:0]    snp_cmd,
    input  logic [AW-1:0] snp_addr,
    input  logic [DW-1:0] snp_data,
    output logic          shared_out,
    output logic          flush_out,
    output logic [DW-1:0] flush_data
);
    localparam int TW = AW - IDXW;

    bus_cmd_e        ctl_cmd;
    logic [IDXW-1:0] a_idx, b_idx;
    line_st_e        a_st, b_st, cw_st, sw_st;
    logic [TW-1:0]   a_tag, b_tag, cw_tag;
    logic [DW-1:0]   a_data, b_data, cw_data, sw_data;
    logic            cw_en, sw_en;

    assign bus_cmd = ctl_cmd;

    dragon_cpu_ctrl #(.AW(AW), .DW(DW), .IDXW(IDXW)) u_ctrl (
        .clk(clk), .rst(rst),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_done(cpu_done), .cpu_hit(cpu_hit), .cpu_rdata(cpu_rdata),
        .snp_busy(snp_valid),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(ctl_cmd),
        .bus_addr(bus_addr), .bus_data(bus_data),
        .bus_shared_in(bus_shared_in), .bus_fill_data(bus_fill_data),
        .a_idx(a_idx), .a_st(a_st), .a_tag(a_tag), .a_data(a_data),
        .wr_en(cw_en), .wr_st(cw_st), .wr_tag(cw_tag), .wr_data(cw_data)
    );

    dragon_snoop #(.AW(AW), .DW(DW), .IDXW(IDXW)) u_snoop (
        .clk(clk), .rst(rst),
        .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr), .snp_data(snp_data),
        .b_idx(b_idx), .b_st(b_st), .b_tag(b_tag), .b_data(b_data),
        .shared_out(shared_out), .flush_out(flush_out), .flush_data(flush_data),
        .wr_en(sw_en), .wr_st(sw_st), .wr_data(sw_data)
    );

    dragon_line_array #(.AW(AW), .DW(DW), .IDXW(IDXW)) u_array (
        .clk(clk), .rst(rst),
        .a_idx(a_idx), .a_st(a_st), .a_tag(a_tag), .a_data(a_data),
        .b_idx(b_idx), .b_st(b_st), .b_tag(b_tag), .b_data(b_data),
        .cpu_we(cw_en), .cpu_idx(a_idx), .cpu_st(cw_st), .cpu_tag(cw_tag), .cpu_data(cw_data),
        .snp_we(sw_en), .snp_idx(b_idx), .snp_st(sw_st), .snp_data(sw_data)
    );

endmodule

// File: tb/sim_dragon_coh_ctrl.sv
`timescale 1ns/1ps
module sim_dragon_coh_ctrl;
    logic        clk = 1'b0;
    logic        rst;
    logic        cpu_req = 0, cpu_we = 0;
    logic [7:0]  cpu_addr = 0;
    logic [15:0] cpu_wdata = 0;
    logic        cpu_done, cpu_hit;
    logic [15:0] cpu_rdata;
    logic        bus_req, bus_gnt = 0;
    logic [1:0]  bus_cmd;
    logic [7:0]  bus_addr;
    logic [15:0] bus_data;
    logic        bus_shared_in = 0;
    logic [15:0] bus_fill_data = 0;
    logic        snp_valid = 0;
    logic [1:0]  snp_cmd = 0;
    logic [7:0]  snp_addr = 0;
    logic [15:0] snp_data = 0;
    logic        shared_out, flush_out;
    logic [15:0] flush_data;

    int n_chk = 0, n_err = 0;
    int ntx;
    logic [1:0]  tx_cmd  [4];
    logic [7:0]  tx_addr [4];
    logic [15:0] tx_data [4];
    logic        o_hit;
    logic [15:0] o_rdata;

    always #2 clk = ~clk;

    dragon_coh_ctrl u0 (
        .clk(clk), .rst(rst),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_done(cpu_done), .cpu_hit(cpu_hit), .cpu_rdata(cpu_rdata),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(bus_cmd),
        .bus_addr(bus_addr), .bus_data(bus_data),
        .bus_shared_in(bus_shared_in), .bus_fill_data(bus_fill_data),
        .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr), .snp_data(snp_data),
        .shared_out(shared_out), .flush_out(flush_out), .flush_data(flush_data)
    );

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    // Processor access; the bench acts as arbiter and logs granted commands.
    task automatic cpu_op(input logic we, input logic [7:0] a, input logic [15:0] d,
                          input logic sh_rd, input logic sh_upd, input logic [15:0] fill,
                          input logic probe, input logic [15:0] probe_exp);
        bit done = 0;
        @(negedge clk);
        cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
        ntx = 0;
        for (int cyc = 0; cyc < 40 && !done; cyc++) begin
            @(negedge clk);
            bus_gnt = 0;
            if (cpu_done) begin
                o_hit = cpu_hit; o_rdata = cpu_rdata;
                cpu_req = 0; done = 1;
            end else if (bus_req) begin
                if (ntx < 4) begin
                    tx_cmd[ntx] = bus_cmd; tx_addr[ntx] = bus_addr; tx_data[ntx] = bus_data;
                end
                if (probe && bus_cmd == 2'd2) begin
                    snp_valid = 1; snp_cmd = 2'd1; snp_addr = a;
                    #1;
                    chk("R5 old copy kept before grant", {flush_out, flush_data}, {1'b1, probe_exp});
                    @(negedge clk);
                    snp_valid = 0; snp_cmd = 0;
                end
                ntx++;
                bus_gnt = 1;
                bus_shared_in = (bus_cmd == 2'd1) ? sh_rd : (bus_cmd == 2'd2) ? sh_upd : 1'b0;
                bus_fill_data = fill;
            end
        end
        if (!done) begin
            chk("R10 request completes", 0, 1);
            cpu_req = 0;
        end
    endtask

    task automatic snoop(input logic [1:0] c, input logic [7:0] a, input logic [15:0] d,
                         input logic exp_sh, input logic exp_fl, input logic [15:0] exp_fd,
                         input string rq);
        @(negedge clk);
        snp_valid = 1; snp_cmd = c; snp_addr = a; snp_data = d;
        #1;
        chk({rq, " shared"}, shared_out, exp_sh);
        chk({rq, " flush"}, flush_out, exp_fl);
        if (exp_fl) chk({rq, " flush data"}, flush_data, exp_fd);
        @(negedge clk);
        snp_valid = 0; snp_cmd = 0;
    endtask

    task automatic t_reset;
        chk("R1 bus_req idle", bus_req, 0);
        chk("R1 cpu_done idle", cpu_done, 0);
        chk("R1 shared idle", shared_out, 0);
        chk("R1 flush idle", flush_out, 0);
        snoop(2'd1, 8'h10, 0, 0, 0, 0, "R1 empty after reset");
    endtask

    task automatic t_read_exclusive;
        cpu_op(0, 8'h04, 0, 0, 0, 16'h00AA, 0, 0);
        chk("R2 one read", ntx, 1);
        chk("R2 read cmd", tx_cmd[0], 1);
        chk("R2 read addr", tx_addr[0], 8'h04);
        chk("R2 miss", o_hit, 0);
        chk("R2 fill data", o_rdata, 16'h00AA);
        cpu_op(0, 8'h04, 0, 0, 0, 0, 0, 0);
        chk("R11 hit no bus", ntx, 0);
        chk("R11 hit flag", o_hit, 1);
        chk("R11 hit data", o_rdata, 16'h00AA);
        cpu_op(1, 8'h04, 16'h0011, 0, 0, 0, 0, 0);
        chk("R4 exclusive write silent", ntx, 0);
        chk("R11 write returns word", o_rdata, 16'h0011);
        cpu_op(1, 8'h04, 16'h0022, 0, 0, 0, 0, 0);
        chk("R4 modified write silent", ntx, 0);
        snoop(2'd1, 8'h04, 0, 1, 1, 16'h0022, "R6 snoop read on modified");
        snoop(2'd1, 8'h04, 0, 1, 1, 16'h0022, "R6 snoop read on owner");
        snoop(2'd2, 8'h04, 16'h0033, 1, 0, 0, "R7 snoop update");
        snoop(2'd1, 8'h04, 0, 1, 0, 0, "R7 owner demoted to shared-clean");
        cpu_op(0, 8'h04, 0, 0, 0, 0, 0, 0);
        chk("R7 update word stored", o_rdata, 16'h0033);
    endtask

    task automatic t_shared_writes;
        cpu_op(0, 8'h05, 0, 1, 0, 16'h0050, 0, 0);
        chk("R2 shared fill data", o_rdata, 16'h0050);
        snoop(2'd1, 8'h05, 0, 1, 0, 0, "R2 filled shared-clean");
        cpu_op(1, 8'h05, 16'h0051, 0, 1, 0, 0, 0);
        chk("R5 one update", ntx, 1);
        chk("R5 update cmd", tx_cmd[0], 2);
        chk("R5 update addr", tx_addr[0], 8'h05);
        chk("R5 update word", tx_data[0], 16'h0051);
        snoop(2'd1, 8'h05, 0, 1, 1, 16'h0051, "R5 now shared-modified");
        cpu_op(1, 8'h05, 16'h0052, 0, 0, 0, 1, 16'h0051);
        chk("R5 owner update", ntx, 1);
        cpu_op(1, 8'h05, 16'h0053, 0, 0, 0, 0, 0);
        chk("R5 unshared update ends modified", ntx, 0);
        snoop(2'd1, 8'h05, 0, 1, 1, 16'h0053, "R5 modified data");
        cpu_op(0, 8'h06, 0, 0, 0, 16'h0060, 0, 0);
        snoop(2'd1, 8'h06, 0, 1, 0, 0, "R6 exclusive no flush");
        cpu_op(1, 8'h06, 16'h0061, 0, 0, 0, 0, 0);
        chk("R6 exclusive became shared-clean", ntx, 1);
        chk("R6 update cmd", tx_cmd[0], 2);
    endtask

    task automatic t_write_miss_replace;
        cpu_op(1, 8'h07, 16'h0071, 1, 1, 16'h0070, 0, 0);
        chk("R3 read then update", ntx, 2);
        chk("R3 first read", tx_cmd[0], 1);
        chk("R3 second update", tx_cmd[1], 2);
        chk("R3 update word", tx_data[1], 16'h0071);
        chk("R3 miss flag", o_hit, 0);
        snoop(2'd1, 8'h07, 0, 1, 1, 16'h0071, "R3 ends shared-modified");
        cpu_op(1, 8'h0B, 16'h00B1, 0, 0, 16'h00B0, 0, 0);
        chk("R9 writeback then read", ntx, 2);
        chk("R9 writeback cmd", tx_cmd[0], 3);
        chk("R9 writeback addr", tx_addr[0], 8'h07);
        chk("R9 writeback data", tx_data[0], 16'h0071);
        chk("R3 read cmd", tx_cmd[1], 1);
        chk("R3 read addr", tx_addr[1], 8'h0B);
        snoop(2'd1, 8'h0B, 0, 1, 1, 16'h00B1, "R3 unshared ends modified");
        snoop(2'd1, 8'h07, 0, 0, 0, 0, "R9 victim gone");
        cpu_op(0, 8'h08, 0, 0, 0, 16'h0080, 0, 0);
        chk("R9 clean victim dropped", ntx, 1);
        chk("R9 clean victim read cmd", tx_cmd[0], 1);
        chk("R2 data", o_rdata, 16'h0080);
        snoop(2'd1, 8'h04, 0, 0, 0, 0, "R9 clean victim gone");
        cpu_op(0, 8'h0A, 0, 1, 0, 16'h00A0, 0, 0);
        chk("R9 modified victim", ntx, 2);
        chk("R9 modified victim cmd", tx_cmd[0], 3);
        chk("R9 modified victim addr", tx_addr[0], 8'h06);
        chk("R9 modified victim data", tx_data[0], 16'h0061);
        chk("R2 read after writeback", o_rdata, 16'h00A0);
    endtask

    task automatic t_share_line;
        snoop(2'd3, 8'h0A, 16'h1234, 0, 0, 0, "R8 writeback snoop ignored");
        snoop(2'd1, 8'h0E, 0, 0, 0, 0, "R8 tag mismatch");
        snoop(2'd1, 8'h0A, 0, 1, 0, 0, "R8 present line");
        cpu_op(0, 8'h0A, 0, 0, 0, 0, 0, 0);
        chk("R8 writeback snoop left data", o_rdata, 16'h00A0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog R10 actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_read_exclusive();
        t_shared_writes();
        t_write_miss_replace();
        t_share_line();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule